// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Events

This block is a byte-addressed register file for a set of general-purpose pins. The pins are divided into a lower bank and an upper bank at a configurable boundary pin. Both banks have the same register layout. Each pin has eight control and status bits: enable, direction, output level, rising-edge enable, falling-edge enable, event enable, secondary route and edge status.

Software uses a plain byte write/read port. Writes are single-cycle strobes and reads are combinational. The block drives pad values and pad output enables. Pad inputs pass through a two-flop synchronizer. Edges are detected on the synchronized samples and latched into sticky status bits. Software clears a status bit by writing 1 to it.

A single level event line is high while any pin has both its status bit and its event enable bit set.

Top module: `gpio_two_bank`

## Requirements
- R1: After reset, every direction bit reads 1 (input). Every enable, level, rising-enable, falling-enable, event-enable, route and status bit reads 0. `pad_oe_o` and `event_o` are 0.
- R2: An address is decoded as follows:
  - `addr_i[5]` selects the bank: 0 is the lower bank, 1 is the upper bank.
  - `addr_i[4:2]` selects the register: 0 enable, 1 direction, 2 level, 3 rising enable, 4 falling enable, 5 event enable, 6 route, 7 status.
  - `addr_i[1:0]` selects the byte.

  A pin below `SPLIT` uses local index p. A pin at or above `SPLIT` uses local index p-`SPLIT` in the upper bank. The pin sits in byte local/8 at bit local%8. Bits with no pin read 0.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. `pad_oe_o[p]` is 1 only while pin p is enabled and is an output. The direction bit reads back as written.
- R4: While a pin is an input, writes to its level bit have no effect. Reading its level bit returns the synchronized pad value, which is visible on the second rising clock edge after the pad changes. While the pin is an output, the level bit returns the stored value, which drives `pad_o[p]`.
- R5: Rising and falling detection are enabled independently. An enabled pin's status bit sets on the third rising clock edge after the pad makes a transition whose edge enable is 1. A transition whose enable is 0 leaves the status bit at 0.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If a clear and a new enabled edge land on the same pin in the same cycle, the status bit stays 1.
- R8: `event_o` is 1 exactly while some pin has both its status bit and its event enable bit at 1. It follows the status register combinationally.
- R9: A pin whose enable bit is 0 latches no edges and drives no output enable, whatever its other bits are.
- R10: The route bit of every pin is writable and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address {bank, register, byte} |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| pad_i | input | NUM_PINS | Pad input values |
| pad_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| event_o | output | 1 | Level event, OR of enabled status bits |

## Verification
Each result has a fixed delay after its stimulus:
- A register write takes effect at the clock edge that samples the strobe.
- A read is valid at once.
- The synchronized level of an input pin appears after two rising edges.
- A status bit, and the event line that follows it, sets after three rising edges.

The bench drives pads and bus inputs at falling edges and samples one time unit later. Level reads check for 0 after one edge and for 1 after two edges. Status reads check for 0 after two edges and for 1 after three edges, so an early or a late pipeline fails a check. The set-wins case places the clear strobe on exactly the third rising edge after a pad transition.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GPIO_ADDR_W = 6;
  localparam int GPIO_BYTES  = 4;

  typedef enum logic [2:0] {
    REG_EN   = 3'd0,
    REG_DIR  = 3'd1,
    REG_LVL  = 3'd2,
    REG_RISE = 3'd3,
    REG_FALL = 3'd4,
    REG_IE   = 3'd5,
    REG_ROUTE= 3'd6,
    REG_STS  = 3'd7
  } gpio_reg_e;

  function automatic logic pin_bank(input int p, input int split);
    return (p >= split);
  endfunction

  function automatic int pin_local(input int p, input int split);
    return (p >= split) ? (p - split) : p;
  endfunction

  function automatic logic [1:0] pin_byte(input int p, input int split);
    int loc;
    loc = pin_local(p, split) / 8;
    return loc[1:0];
  endfunction

  function automatic logic [2:0] pin_bit(input int p, input int split);
    int loc;
    loc = pin_local(p, split) % 8;
    return loc[2:0];
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] samp_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pad_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign samp_o = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] we_i,
  input  logic       wbit_i,
  input  logic       samp_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic [7:0] field_o,
  output logic       en_o,
  output logic       dir_o,
  output logic       lvl_o,
  output logic       sts_o,
  output logic       irq_o
);
  logic en_q, dir_q, lvl_q, re_q, fe_q, ie_q, route_q, sts_q;
  logic hit, clr;

  assign hit = en_q & ((rise_i & re_q) | (fall_i & fe_q));
  assign clr = we_i[REG_STS] & wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      dir_q   <= 1'b1;
      lvl_q   <= 1'b0;
      re_q    <= 1'b0;
      fe_q    <= 1'b0;
      ie_q    <= 1'b0;
      route_q <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      if (we_i[REG_EN])    en_q    <= wbit_i;
      if (we_i[REG_DIR])   dir_q   <= wbit_i;
      // level is read-only while the pin is an input
      if (we_i[REG_LVL] && !dir_q) lvl_q <= wbit_i;
      if (we_i[REG_RISE])  re_q    <= wbit_i;
      if (we_i[REG_FALL])  fe_q    <= wbit_i;
      if (we_i[REG_IE])    ie_q    <= wbit_i;
      if (we_i[REG_ROUTE]) route_q <= wbit_i;
      // new edge beats a same-cycle clear
      sts_q <= hit | (sts_q & ~clr);
    end
  end

  always_comb begin
    field_o            = '0;
    field_o[REG_EN]    = en_q;
    field_o[REG_DIR]   = dir_q;
    field_o[REG_LVL]   = dir_q ? samp_i : lvl_q;
    field_o[REG_RISE]  = re_q;
    field_o[REG_FALL]  = fe_q;
    field_o[REG_IE]    = ie_q;
    field_o[REG_ROUTE] = route_q;
    field_o[REG_STS]   = sts_q;
  end

  assign en_o  = en_q;
  assign dir_o = dir_q;
  assign lvl_o = lvl_q;
  assign sts_o = sts_q;
  assign irq_o = sts_q & ie_q;
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 14,
  parameter int SPLIT    = 10
) (
  input  logic [GPIO_ADDR_W-1:0]    addr_i,
  input  logic [NUM_PINS-1:0][7:0]  fields_i,
  output logic [7:0]                rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i[5] == pin_bank(p, SPLIT) && addr_i[1:0] == pin_byte(p, SPLIT))
        rdata_o[pin_bit(p, SPLIT)] = fields_i[p][addr_i[4:2]];
    end
  end
endmodule

// File: rtl/gpio_two_bank.sv
module gpio_two_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 14,
  parameter int SPLIT    = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [GPIO_ADDR_W-1:0] addr_i,
  input  logic                   wr_en_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [NUM_PINS-1:0]    pad_i,
  output logic [NUM_PINS-1:0]    pad_o,
  output logic [NUM_PINS-1:0]    pad_oe_o,
  output logic                   event_o
);
  localparam int UPPER_PINS = NUM_PINS - SPLIT;

  logic [NUM_PINS-1:0]      samp, rise, fall;
  logic [NUM_PINS-1:0]      en_v, dir_v, lvl_v, sts_v, irq_v, sts_clr;
  logic [NUM_PINS-1:0][7:0] fields;

  gpio_sync #(.N(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pad_i (pad_i),
    .samp_o(samp),
    .rise_o(rise),
    .fall_o(fall)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic       BANK = pin_bank(p, SPLIT);
    localparam logic [1:0] BYTE = pin_byte(p, SPLIT);
    localparam logic [2:0] BITP = pin_bit(p, SPLIT);

    logic       sel;
    logic [7:0] we;

    assign sel = wr_en_i && (addr_i[5] == BANK) && (addr_i[1:0] == BYTE);
    assign we  = sel ? (8'b1 << addr_i[4:2]) : 8'b0;
    assign sts_clr[p] = sel && (addr_i[4:2] == REG_STS) && wdata_i[BITP];

    gpio_pin_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .wbit_i (wdata_i[BITP]),
      .samp_i (samp[p]),
      .rise_i (rise[p]),
      .fall_i (fall[p]),
      .field_o(fields[p]),
      .en_o   (en_v[p]),
      .dir_o  (dir_v[p]),
      .lvl_o  (lvl_v[p]),
      .sts_o  (sts_v[p]),
      .irq_o  (irq_v[p])
    );
  end

  gpio_read_mux #(.NUM_PINS(NUM_PINS), .SPLIT(SPLIT)) u_rmux (
    .addr_i  (addr_i),
    .fields_i(fields),
    .rdata_o (rdata_o)
  );

  assign pad_o    = lvl_v;
  assign pad_oe_o = en_v & ~dir_v;
  assign event_o  = |irq_v;

  initial begin
    if (SPLIT < 1 || SPLIT > 8 * GPIO_BYTES || UPPER_PINS < 1 || UPPER_PINS > 8 * GPIO_BYTES)
      $error("gpio_two_bank: bank split out of range");
  end
endmodule

// File: rtl/gpio_two_bank_chk.sv
module gpio_two_bank_chk #(
  parameter int NUM_PINS = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                event_o,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] lvl_q,
  input logic [NUM_PINS-1:0] sts_q,
  input logic [NUM_PINS-1:0] sts_clr,
  input logic [NUM_PINS-1:0] rise,
  input logic [NUM_PINS-1:0] fall
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assert_lvl_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_q[p] |=> $stable(lvl_q[p]));
    assert_sts_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[p] && !sts_clr[p]) |=> sts_q[p]);
    assert_sts_needs_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sts_q[p] && !rise[p] && !fall[p]) |=> !sts_q[p]);
  end

  assert_event_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (sts_q != '0));
endmodule

bind gpio_two_bank gpio_two_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .event_o(event_o),
  .dir_q  (dir_v),
  .lvl_q  (lvl_v),
  .sts_q  (sts_v),
  .sts_clr(sts_clr),
  .rise   (rise),
  .fall   (fall)
);

// File: tb/tb_gpio_two_bank.sv
`timescale 1ns/1ps
module tb_gpio_two_bank;
  localparam int N = 14;
  localparam int SP = 10;

  logic         clk_i = 0;
  logic         rst_ni = 0;
  logic [5:0]   addr = 0;
  logic         wr_en = 0;
  logic [7:0]   wdata = 0;
  logic [7:0]   rdata;
  logic [N-1:0] pads = 0;
  logic [N-1:0] pad_o, pad_oe_o;
  logic         event_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  gpio_two_bank #(.NUM_PINS(N), .SPLIT(SP)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pads), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .event_o(event_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bank_of(int p); return (p >= SP) ? 1 : 0; endfunction
  function automatic int loc_of(int p); return (p >= SP) ? p - SP : p; endfunction
  function automatic logic [5:0] addr_of(int p, int r);
    return 6'(bank_of(p) * 32 + r * 4 + loc_of(p) / 8);
  endfunction
  function automatic int bit_of(int p); return loc_of(p) % 8; endfunction

  function automatic logic [7:0] valid_mask(int b, int y);
    logic [7:0] m = 0;
    for (int k = 0; k < 8; k++) begin
      int loc = y * 8 + k;
      if (b == 0 ? (loc < SP) : (SP + loc < N)) m[k] = 1'b1;
    end
    return m;
  endfunction

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    addr = a; wr_en = 0; #1; d = rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i); addr = a; wdata = d; wr_en = 1;
    @(posedge clk_i); @(negedge clk_i); wr_en = 0;
  endtask

  task automatic rd_bit(input int p, input int r, output logic v);
    logic [7:0] d;
    rd(addr_of(p, r), d);
    v = d[bit_of(p)];
  endtask

  task automatic rmw(input int p, input int r, input logic v);
    logic [7:0] d;
    rd(addr_of(p, r), d);
    d[bit_of(p)] = v;
    wr(addr_of(p, r), d);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clr_sts(input int p);
    wr(addr_of(p, 7), 8'(1 << bit_of(p)));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);

    // R1 and R2: reset contents of every register byte in both banks
    check("R1 oe", int'(pad_oe_o), 0);
    check("R1 event", int'(event_o), 0);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++)
        for (int y = 0; y < 4; y++) begin
          rd(6'(b * 32 + r * 4 + y), d);
          check($sformatf("R1 R2 reset b%0d r%0d y%0d", b, r, y), int'(d),
                r == 1 ? int'(valid_mask(b, y)) : 0);
        end

    // R2 R10: writable registers read back only the mapped bits
    for (int b = 0; b < 2; b++)
      for (int y = 0; y < 4; y++) begin
        for (int r = 0; r < 7; r++)
          if (r != 1 && r != 2) wr(6'(b * 32 + r * 4 + y), 8'hFF);
        for (int r = 3; r < 7; r++) begin
          rd(6'(b * 32 + r * 4 + y), d);
          check($sformatf("R2 R10 fill b%0d r%0d y%0d", b, r, y), int'(d), int'(valid_mask(b, y)));
          wr(6'(b * 32 + r * 4 + y), 8'h00);
          rd(6'(b * 32 + r * 4 + y), d);
          check($sformatf("R10 zero b%0d r%0d y%0d", b, r, y), int'(d), 0);
        end
      end
    cyc(4);
    check("R5 no spurious status", int'(event_o), 0);

    for (int p = 0; p < N; p++) begin
      // R4: level write ignored while input
      rmw(p, 2, 1'b1);
      check($sformatf("R4 pad_o pin %0d", p), int'(pad_o[p]), 0);
      rd_bit(p, 2, v);
      check($sformatf("R4 lvl in pin %0d", p), int'(v), 0);

      // R5 R4 R8: rising edge timing
      rmw(p, 3, 1'b1);
      rmw(p, 5, 1'b1);
      @(negedge clk_i); pads[p] = 1'b1;
      cyc(1);
      rd_bit(p, 2, v); check($sformatf("R4 lvl 1 edge pin %0d", p), int'(v), 0);
      cyc(1);
      rd_bit(p, 2, v); check($sformatf("R4 lvl 2 edges pin %0d", p), int'(v), 1);
      rd_bit(p, 7, v); check($sformatf("R5 sts 2 edges pin %0d", p), int'(v), 0);
      cyc(1);
      rd_bit(p, 7, v); check($sformatf("R5 sts 3 edges pin %0d", p), int'(v), 1);
      check($sformatf("R8 event set pin %0d", p), int'(event_o), 1);

      // R8 event enable gating
      rmw(p, 5, 1'b0);
      check($sformatf("R8 event masked pin %0d", p), int'(event_o), 0);
      rmw(p, 5, 1'b1);
      check($sformatf("R8 event unmasked pin %0d", p), int'(event_o), 1);

      // R6 write-one-to-clear
      wr(addr_of(p, 7), 8'h00);
      rd_bit(p, 7, v); check($sformatf("R6 write0 pin %0d", p), int'(v), 1);
      clr_sts(p);
      rd_bit(p, 7, v); check($sformatf("R6 write1 pin %0d", p), int'(v), 0);
      check($sformatf("R8 event clear pin %0d", p), int'(event_o), 0);

      // R5 falling edge with only rise enabled, then only fall enabled
      @(negedge clk_i); pads[p] = 1'b0;
      cyc(4);
      rd_bit(p, 7, v); check($sformatf("R5 fall ignored pin %0d", p), int'(v), 0);
      rmw(p, 4, 1'b1);
      rmw(p, 3, 1'b0);
      @(negedge clk_i); pads[p] = 1'b1;
      cyc(4);
      rd_bit(p, 7, v); check($sformatf("R5 rise ignored pin %0d", p), int'(v), 0);
      @(negedge clk_i); pads[p] = 1'b0;
      cyc(4);
      rd_bit(p, 7, v); check($sformatf("R5 fall seen pin %0d", p), int'(v), 1);

      // R7 clear in the same cycle as a new edge
      rmw(p, 3, 1'b1);
      @(negedge clk_i); pads[p] = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      @(posedge clk_i); @(negedge clk_i);
      addr = addr_of(p, 7); wdata = 8'(1 << bit_of(p)); wr_en = 1;
      @(posedge clk_i); @(negedge clk_i); wr_en = 0;
      rd_bit(p, 7, v); check($sformatf("R7 set wins pin %0d", p), int'(v), 1);
      clr_sts(p);
      rd_bit(p, 7, v); check($sformatf("R6 clear pin %0d", p), int'(v), 0);

      // R3 R4 output mode
      rmw(p, 1, 1'b0);
      check($sformatf("R3 oe pin %0d", p), int'(pad_oe_o[p]), 1);
      check($sformatf("R3 oe others pin %0d", p), int'(pad_oe_o & ~(N'(1) << p)), 0);
      rd_bit(p, 1, v); check($sformatf("R3 dir read pin %0d", p), int'(v), 0);
      rmw(p, 2, 1'b1);
      check($sformatf("R4 pad_o high pin %0d", p), int'(pad_o[p]), 1);
      rmw(p, 2, 1'b0);
      check($sformatf("R4 pad_o low pin %0d", p), int'(pad_o[p]), 0);
      rd_bit(p, 2, v); check($sformatf("R4 stored lvl pin %0d", p), int'(v), 0);

      // R9 disabled pin
      rmw(p, 0, 1'b0);
      check($sformatf("R9 oe off pin %0d", p), int'(pad_oe_o[p]), 0);
      rmw(p, 1, 1'b1);
      @(negedge clk_i); pads[p] = 1'b0;
      cyc(4);
      rd_bit(p, 7, v); check($sformatf("R9 no edge pin %0d", p), int'(v), 0);
      rmw(p, 0, 1'b1);
      rmw(p, 3, 1'b0);
      rmw(p, 4, 1'b0);
      rmw(p, 5, 1'b0);
      cyc(2);
      check($sformatf("R8 idle pin %0d", p), int'(event_o), 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule